// File: doc/BRIEF.md
# Dual-Channel Serial Converter Code Register

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The block samples all three wires with a faster system clock and shifts in data bits on serial clock falling edges. When a frame ends, it decodes the four upper program bits of the word. It then updates two 12-bit channel code registers and a 12-bit staging register.

The staging register allows both channels to change together. The host first parks a code for channel B in the staging register. A single write to channel A then loads A and, in the same cycle, copies the staged code into B. Every completed word also sets a speed-mode flag and a power-down flag. The `AUTO_END` parameter selects a variant in which the frame ends by itself after sixteen serial clock falling edges. In that variant, any later edges are ignored until the select line falls again.

Top module: `dual_dac_frontend`

## Requirements
- R1: After reset, `code_a`, `code_b` and the staging register are all zero, `fast_mode` is 0 and `power_down` is 0.
- R2: A frame opens when `cs_n` falls and clears the shift register. Each `sclk` falling edge while `cs_n` is low shifts in `sdin`, most significant bit first. The word's bit 15 down to bit 12 are program bits, and bit 11 down to bit 0 are the code. A word of fewer than 16 bits is right-aligned with zeros above it.
- R3: `sclk` edges while `cs_n` is high change no output and no register.
- R4: When a word with bit 15 = 1 completes, `code_a` takes the code and `code_b` takes the staging register. The staging register keeps its value.
- R5: When a word with bit 15 = 0 and bit 12 = 0 completes, `code_b` and the staging register both take the code. `code_a` keeps its value.
- R6: When a word with bit 15 = 0 and bit 12 = 1 completes, only the staging register takes the code. This becomes visible in `code_b` on the next write with bit 15 = 1.
- R7: Every completed word sets `fast_mode` to its bit 14 (1 = fast) and `power_down` to its bit 13 (1 = powered down).
- R8: The registers change only when a frame ends, never while bits are still being shifted with `cs_n` low.
- R9: With `AUTO_END` = 0, the frame ends on the `cs_n` rising edge. If more than 16 bits were shifted, the last 16 are used.
- R10: With `AUTO_END` = 1, the update happens right after the 16th `sclk` falling edge of the frame. Further edges, and the `cs_n` rise that follows, cause no second update.
- R11: With `AUTO_END` = 1, a `cs_n` rise before the 16th edge ends the frame early and uses the bits received so far (R2 alignment).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock, idles high; data taken on falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| code_a | output | 12 | Channel A code register |
| code_b | output | 12 | Channel B code register |
| fast_mode | output | 1 | Speed mode flag from the last word |
| power_down | output | 1 | Power-down flag from the last word |

## Verification
The hardest state to reach from the ports is a staging register that differs from `code_b`. It exists only between a stage-only write and the next channel A write, and no output shows it directly. The vector table therefore runs chains of stage-only writes, each followed by an A write, so that the staged code comes out in `code_b` and is compared there. For the auto-ending variant, the stimulus holds `cs_n` low past the sixteenth edge and keeps clocking ones. This shows that neither the extra bits nor the late `cs_n` rise trigger a second update.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int CODE_W  = 12;
    localparam int PROG_W  = 4;
    localparam int WORD_W  = CODE_W + PROG_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    // Program bit positions within the program nibble (behaviour depends on them)
    localparam int P_TARGET_A = 3;   // word bit 15
    localparam int P_SPEED    = 2;   // word bit 14
    localparam int P_PDOWN    = 1;   // word bit 13
    localparam int P_STAGE_ONLY = 0; // word bit 12

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [PROG_W-1:0] prog;
        code_t             code;
    } cmd_word_t;

    typedef struct packed {
        logic load_a;
        logic load_b_from_stage;
        logic load_b_from_code;
        logic load_stage;
        logic fast;
        logic pdown;
    } cmd_ctrl_t;

    function automatic cmd_ctrl_t decode_prog(input logic [PROG_W-1:0] p);
        cmd_ctrl_t c;
        c.load_a            = p[P_TARGET_A];
        c.load_b_from_stage = p[P_TARGET_A];
        c.load_b_from_code  = !p[P_TARGET_A] && !p[P_STAGE_ONLY];
        c.load_stage        = !p[P_TARGET_A];
        c.fast              = p[P_SPEED];
        c.pdown             = p[P_PDOWN];
        return c;
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else if (g == 0) chain[g] <= d;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dacfe_rx.sv
module dacfe_rx
    import dacfe_pkg::*;
#(
    parameter bit AUTO_END = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdin_s,
    output logic              frame_done,
    output logic [WORD_W-1:0] frame_word
);
    logic              cs_prev, sclk_prev;
    logic              cs_fall, cs_rise, sclk_fall;
    logic              active;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg, shreg_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b1;
        end else begin
            cs_prev   <= cs_n_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_fall   = cs_prev && !cs_n_s;
    assign cs_rise   = !cs_prev && cs_n_s;
    assign sclk_fall = sclk_prev && !sclk_s;
    assign shreg_nxt = {shreg[WORD_W-2:0], sdin_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            frame_word <= '0;
        end else begin
            frame_done <= 1'b0;
            if (cs_fall) begin
                active  <= 1'b1;
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (active) begin
                if (cs_rise) begin
                    frame_done <= 1'b1;
                    frame_word <= shreg;
                    active     <= 1'b0;
                end else if (sclk_fall && !cs_n_s) begin
                    shreg <= shreg_nxt;
                    if (bit_cnt != CNT_W'(WORD_W)) bit_cnt <= bit_cnt + 1'b1;
                    if (AUTO_END && bit_cnt == CNT_W'(WORD_W - 1)) begin
                        frame_done <= 1'b1;
                        frame_word <= shreg_nxt;
                        active     <= 1'b0;
                    end
                end
            end
        end
    end

    // R10: counter never passes the word length
    always_comb begin
        a_r10_count_bound: assert (rst || bit_cnt <= CNT_W'(WORD_W));
    end

    // R3: outside a frame the shift register holds
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!active && !cs_fall) |=> $stable(shreg));

    // R10: a frame end closes the frame, so no back-to-back ends
    a_r10_single_end: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    a_r10_closed_after_end: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !active);
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] frame_word,
    output code_t             reg_a,
    output code_t             reg_b,
    output logic              fast_mode,
    output logic              power_down
);
    cmd_word_t w;
    cmd_ctrl_t ctl;
    code_t     stage;

    assign w   = cmd_word_t'(frame_word);
    assign ctl = decode_prog(w.prog);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a      <= '0;
            reg_b      <= '0;
            stage      <= '0;
            fast_mode  <= 1'b0;
            power_down <= 1'b0;
        end else if (frame_done) begin
            if (ctl.load_a)            reg_a <= w.code;
            if (ctl.load_b_from_stage) reg_b <= stage;
            else if (ctl.load_b_from_code) reg_b <= w.code;
            if (ctl.load_stage)        stage <= w.code;
            fast_mode  <= ctl.fast;
            power_down <= ctl.pdown;
        end
    end

    a_r4_load_a: assert property (@(posedge clk) disable iff (rst)
        (frame_done && frame_word[15]) |=> (reg_a == $past(frame_word[CODE_W-1:0])));

    a_r4_stage_keep: assert property (@(posedge clk) disable iff (rst)
        (frame_done && frame_word[15]) |=> ($stable(stage) && reg_b == $past(stage)));

    a_r5_load_b: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame_word[15] && !frame_word[12])
        |=> (reg_b == $past(frame_word[CODE_W-1:0]) && $stable(reg_a)));

    a_r6_stage_only: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame_word[15] && frame_word[12])
        |=> ($stable(reg_a) && $stable(reg_b)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> ($stable(reg_a) && $stable(reg_b) && $stable(stage)
                         && $stable(fast_mode) && $stable(power_down)));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
    import dacfe_pkg::*;
#(
    parameter bit AUTO_END    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              fast_mode,
    output logic              power_down
);
    logic [2:0]        pins_s;
    logic              done;
    logic [WORD_W-1:0] word;

    dacfe_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdin}),
        .q   (pins_s)
    );

    dacfe_rx #(
        .AUTO_END(AUTO_END)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_n_s     (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .sdin_s     (pins_s[0]),
        .frame_done (done),
        .frame_word (word)
    );

    dacfe_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .frame_done (done),
        .frame_word (word),
        .reg_a      (code_a),
        .reg_b      (code_b),
        .fast_mode  (fast_mode),
        .power_down (power_down)
    );
endmodule

// File: tb/dual_dac_frontend_bench.sv
module dual_dac_frontend_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_m = 1'b1, cs_a = 1'b1, sclk = 1'b1, sdin = 1'b0;
    logic [11:0] a_m, b_m, a_a, b_a;
    logic f_m, p_m, f_a, p_a;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dual_dac_frontend #(.AUTO_END(1'b0)) u_dual_dac_frontend (
        .clk(clk), .rst(rst), .cs_n(cs_m), .sclk(sclk), .sdin(sdin),
        .code_a(a_m), .code_b(b_m), .fast_mode(f_m), .power_down(p_m));

    dual_dac_frontend #(.AUTO_END(1'b1)) u_dual_dac_frontend_auto (
        .clk(clk), .rst(rst), .cs_n(cs_a), .sclk(sclk), .sdin(sdin),
        .code_a(a_a), .code_b(b_a), .fast_mode(f_a), .power_down(p_a));

    // {word, exp_a, exp_b, exp_fast, exp_pd} for the select-terminated instance
    localparam logic [41:0] VEC [9] = '{
        {16'h8ABC, 12'hABC, 12'h000, 1'b0, 1'b0},
        {16'h4123, 12'hABC, 12'h123, 1'b1, 1'b0},
        {16'h5FFF, 12'hABC, 12'h123, 1'b1, 1'b0},
        {16'hC800, 12'h800, 12'hFFF, 1'b1, 1'b0},
        {16'h2456, 12'h800, 12'h456, 1'b0, 1'b1},
        {16'h1001, 12'h800, 12'h456, 1'b0, 1'b0},
        {16'h1777, 12'h800, 12'h456, 1'b0, 1'b0},
        {16'hA000, 12'h000, 12'h777, 1'b0, 1'b1},
        {16'h8FFF, 12'hFFF, 12'h777, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i];
            waitc(4);
            sclk = 1'b0;
            waitc(4);
            sclk = 1'b1;
        end
    endtask

    task automatic frame(input bit auto_dut, input logic [31:0] bits, input int n);
        if (auto_dut) cs_a = 1'b0; else cs_m = 1'b0;
        waitc(4);
        shift_bits(bits, n);
        waitc(4);
        if (auto_dut) cs_a = 1'b1; else cs_m = 1'b1;
        waitc(10);
    endtask

    task automatic check_main(input string tag, input logic [11:0] ea, input logic [11:0] eb,
                              input logic ef, input logic ep);
        check({tag, " code_a"}, 32'(a_m), 32'(ea));
        check({tag, " code_b"}, 32'(b_m), 32'(eb));
        check({tag, " fast"},   32'(f_m), 32'(ef));
        check({tag, " pdown"},  32'(p_m), 32'(ep));
    endtask

    task automatic check_auto(input string tag, input logic [11:0] ea, input logic [11:0] eb,
                              input logic ef, input logic ep);
        check({tag, " code_a"}, 32'(a_a), 32'(ea));
        check({tag, " code_b"}, 32'(b_a), 32'(eb));
        check({tag, " fast"},   32'(f_a), 32'(ef));
        check({tag, " pdown"},  32'(p_a), 32'(ep));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(5);
        check_main("R1 reset main", 12'h000, 12'h000, 1'b0, 1'b0);
        check_auto("R1 reset auto", 12'h000, 12'h000, 1'b0, 1'b0);

        // R2 R4 R5 R6 R7: vector table
        for (int i = 0; i < 9; i++) begin
            frame(1'b0, 32'(VEC[i][41:26]), 16);
            check_main($sformatf("R4/R5/R6/R7 vec%0d", i),
                       VEC[i][25:14], VEC[i][13:2], VEC[i][1], VEC[i][0]);
        end
        // auto instance saw all those clocks with its select high: R3
        check_auto("R3 auto idle during main frames", 12'h000, 12'h000, 1'b0, 1'b0);

        // R3: clocks with select high on main
        shift_bits(32'hFFFF, 10);
        waitc(10);
        check_main("R3 idle clocks", 12'hFFF, 12'h777, 1'b0, 1'b0);

        // R8: no update while select still low
        cs_m = 1'b0; waitc(4);
        shift_bits(32'h4AAA, 16);
        waitc(12);
        check_main("R8 mid frame", 12'hFFF, 12'h777, 1'b0, 1'b0);
        cs_m = 1'b1; waitc(10);
        check_main("R8 after end", 12'hFFF, 12'hAAA, 1'b1, 1'b0);

        // R9: 20 bits, last 16 used -> 0x0DEF
        frame(1'b0, 32'hF0DEF, 20);
        check_main("R9 overlong", 12'hFFF, 12'hDEF, 1'b0, 1'b0);

        // R2: short frame right-aligned, 12 bits -> word 0x0123 -> B,stage
        frame(1'b0, 32'h123, 12);
        check_main("R2 short frame", 12'hFFF, 12'h123, 1'b0, 1'b0);

        // R10: auto end after 16th edge, select still low
        cs_a = 1'b0; waitc(4);
        shift_bits(32'hC321, 16);
        waitc(12);
        check_auto("R10 auto update", 12'h321, 12'h000, 1'b1, 1'b0);
        shift_bits(32'hFF, 8);
        waitc(12);
        check_auto("R10 extra clocks", 12'h321, 12'h000, 1'b1, 1'b0);
        cs_a = 1'b1; waitc(10);
        check_auto("R10 late rise", 12'h321, 12'h000, 1'b1, 1'b0);

        // R11: early end after 12 bits -> word 0x05A5 -> B,stage
        frame(1'b1, 32'h5A5, 12);
        check_auto("R11 early end", 12'h321, 12'h5A5, 1'b0, 1'b0);
        frame(1'b1, 32'h1ABC, 16);
        frame(1'b1, 32'h8000, 16);
        check_auto("R6 auto staged copy", 12'h000, 12'hABC, 1'b0, 1'b0);

        // R1: reset after activity
        @(negedge clk); rst = 1'b1;
        waitc(3);
        rst = 1'b0;
        waitc(5);
        check_main("R1 re-reset main", 12'h000, 12'h000, 1'b0, 1'b0);
        check_auto("R1 re-reset auto", 12'h000, 12'h000, 1'b0, 1'b0);
        // staging cleared by reset: A write copies zero into B
        frame(1'b0, 32'h8111, 16);
        check_main("R1 stage cleared", 12'h111, 12'h000, 1'b0, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule